// File: doc/BRIEF.md
# Copy-Back Store-Miss Line Controller

This block sequences a store that has missed in a direct-mapped copy-back data cache with 32-byte lines. On acceptance it reads the indexed line from the tag and data arrays. If that line is valid and dirty, it parks the line and its line address in a one-line eviction buffer. In the same cycle it places the store bytes into a line assembly register and releases the CPU.

It then refills the line from external memory. The refill runs eight 32-bit beats, starting at the longword that holds the store address and wrapping around the line. A per-byte written mask keeps refill data out of the bytes the store already wrote. When the last refill beat lands, the assembled line is written to the arrays together with the new tag, and the valid and dirty bits are set. Only after that does the controller drain the parked victim to memory in eight write beats.

The controller takes a new miss only when it is idle. A second miss therefore waits through the refill, the array write and any drain.

Top module: `cb_store_miss`

## Requirements
- R1: While idle, `arr_idx` equals `st_addr[13:5]`, so the arrays present the line selected by those address bits. `st_addr[4:0]` gives the byte within the line.
- R2: If the indexed line is valid and dirty at acceptance, its line data and the address `{tag, index}` are captured. They are later written back unchanged: beat k carries bytes 4k..4k+3 of the victim to address `{tag, index, k, 2'b00}`.
- R3: `st_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Byte j of `st_data` lands at line byte `st_addr[4:0] + j`. The store address is aligned to its size.
- R4: The refill issues exactly eight read beats. Beat i reads longword `(st_addr[4:2] + i) mod 8` of the missed line.
- R5: Refill data fills every line byte the store did not write. It never replaces a byte the store wrote.
- R6: In the cycle after the eighth read beat, `arr_we` is high for one cycle. It writes `st_addr[28:14]` as the tag and the assembled line, and sets the valid and dirty bits.
- R7: When a victim was captured, the eight write beats run in longword order 0..7 and start in the cycle after `arr_we`. With no victim, no write beat is issued and the block returns to idle.
- R8: While idle, `st_ready` is high. A store is accepted in the cycle where `st_valid` and `st_ready` are both high. The CPU is never held for the refill or the drain of that store.
- R9: From acceptance until the array write (clean victim) or the last drain beat (dirty victim), `st_ready` stays low, so a further miss stalls.
- R10: A memory request held with `mem_ready` low keeps `mem_valid`, `mem_we` and `mem_addr` unchanged into the next cycle.
- R11: After reset, `st_ready` is high and both `mem_valid` and `arr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 1 | Missed store present |
| st_ready | output | 1 | Store accepted and merged this cycle |
| st_addr | input | 29 | Physical byte address of the store |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data, right-aligned |
| arr_idx | output | 9 | Line index to the tag and data arrays |
| arr_tag_rd | input | 15 | Tag of the indexed line |
| arr_valid_rd | input | 1 | Valid bit of the indexed line |
| arr_dirty_rd | input | 1 | Dirty bit of the indexed line |
| arr_line_rd | input | 256 | Data of the indexed line |
| arr_we | output | 1 | Write tag and line, set valid and dirty |
| arr_tag_wr | output | 15 | Tag written |
| arr_line_wr | output | 256 | Line data written |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 29 | Longword-aligned beat address |
| mem_wdata | output | 32 | Write beat data |
| mem_ready | input | 1 | Beat taken this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read beat |

## Verification
The assertions assume the following about the inputs:
- The arrays answer `arr_idx` in the same cycle.
- Read data is valid in the cycle that `mem_ready` accepts a read beat.
- Stores are aligned to their size.

The bench plays both the arrays and memory. It returns a fixed function of the beat address as read data and only ever issues aligned stores. It drives `mem_ready` either constantly high or in an irregular pattern, so that stalled beats are exercised. It also keeps a second store pending while a drain is running.

// File: rtl/cb_store_miss.sv
module cb_store_miss #(
  parameter int PA_W    = 29,
  parameter int IDX_W   = 9,
  parameter int LINE_LW = 8,
  localparam int LINE_B    = LINE_LW * 4,
  localparam int OFF_W     = $clog2(LINE_B),
  localparam int LW_W      = $clog2(LINE_LW),
  localparam int LA_W      = PA_W - OFF_W,
  localparam int TAG_W     = LA_W - IDX_W,
  localparam int LINE_BITS = LINE_B * 8
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [PA_W-1:0]      st_addr,
  input  logic [1:0]           st_size,
  input  logic [63:0]          st_data,
  output logic [IDX_W-1:0]     arr_idx,
  input  logic [TAG_W-1:0]     arr_tag_rd,
  input  logic                 arr_valid_rd,
  input  logic                 arr_dirty_rd,
  input  logic [LINE_BITS-1:0] arr_line_rd,
  output logic                 arr_we,
  output logic [TAG_W-1:0]     arr_tag_wr,
  output logic [LINE_BITS-1:0] arr_line_wr,
  output logic                 mem_valid,
  output logic                 mem_we,
  output logic [PA_W-1:0]      mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_ready,
  input  logic [31:0]          mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WRITE, S_DRAIN} state_t;
  localparam logic [LW_W-1:0] LAST = LW_W'(LINE_LW - 1);

  state_t                state;
  logic [LA_W-1:0]       miss_la;
  logic [LW_W-1:0]       start_lw;
  logic [LW_W-1:0]       beat;
  logic [LINE_BITS-1:0]  fill_line;
  logic [LINE_B-1:0]     wr_mask;
  logic [LINE_BITS-1:0]  wb_line;
  logic [LA_W-1:0]       wb_la;
  logic                  wb_full;

  logic                  accept, rd_hs, wr_hs;
  logic [LW_W-1:0]       cur_lw;
  logic [8:0]            lane;
  logic [LINE_B-1:0]     st_bmask;
  logic [LINE_BITS-1:0]  st_bline;

  assign st_ready = (state == S_IDLE);
  assign accept   = st_valid && st_ready;
  assign cur_lw   = start_lw + beat;

  assign lane     = (9'd1 << (4'd1 << st_size)) - 9'd1;
  assign st_bmask = LINE_B'(lane[7:0]) << st_addr[OFF_W-1:0];
  assign st_bline = LINE_BITS'(st_data) << {st_addr[OFF_W-1:0], 3'b000};

  assign arr_idx     = (state == S_IDLE) ? st_addr[OFF_W +: IDX_W] : miss_la[IDX_W-1:0];
  assign arr_we      = (state == S_WRITE);
  assign arr_tag_wr  = miss_la[LA_W-1:IDX_W];
  assign arr_line_wr = fill_line;

  assign mem_valid = (state == S_FILL) || (state == S_DRAIN);
  assign mem_we    = (state == S_DRAIN);
  assign mem_addr  = mem_we ? {wb_la, beat, 2'b00} : {miss_la, cur_lw, 2'b00};
  assign mem_wdata = wb_line[{beat, 5'b00000} +: 32];
  assign rd_hs     = mem_valid && !mem_we && mem_ready;
  assign wr_hs     = mem_valid && mem_we && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      miss_la   <= '0;
      start_lw  <= '0;
      beat      <= '0;
      fill_line <= '0;
      wr_mask   <= '0;
      wb_line   <= '0;
      wb_la     <= '0;
      wb_full   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          miss_la   <= st_addr[PA_W-1:OFF_W];
          start_lw  <= st_addr[OFF_W-1:2];
          beat      <= '0;
          fill_line <= st_bline;
          wr_mask   <= st_bmask;
          wb_full   <= arr_valid_rd && arr_dirty_rd;
          if (arr_valid_rd && arr_dirty_rd) begin
            wb_line <= arr_line_rd;
            wb_la   <= {arr_tag_rd, st_addr[OFF_W +: IDX_W]};
          end
          state <= S_FILL;
        end
        S_FILL: if (rd_hs) begin
          for (int k = 0; k < 4; k++)
            if (!wr_mask[{cur_lw, 2'(k)}])
              fill_line[{cur_lw, 2'(k), 3'b000} +: 8] <= mem_rdata[8*k +: 8];
          beat <= beat + 1'b1;
          if (beat == LAST) state <= S_WRITE;
        end
        S_WRITE: begin
          beat  <= '0;
          state <= wb_full ? S_DRAIN : S_IDLE;
        end
        S_DRAIN: if (wr_hs) begin
          beat <= beat + 1'b1;
          if (beat == LAST) begin
            wb_full <= 1'b0;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !st_ready);

  // R4
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && beat != LAST) |=> (mem_valid && !mem_we &&
      mem_addr[PA_W-1:OFF_W] == $past(mem_addr[PA_W-1:OFF_W]) &&
      mem_addr[OFF_W-1:2] == $past(mem_addr[OFF_W-1:2]) + LW_W'(1)));

  // R6
  write_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> $past(rd_hs));

  // R7
  drain_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !$past(mem_valid && mem_we)) |-> $past(arr_we));

  // R10
  hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)));

endmodule

// File: tb/test_cb_store_miss.sv
`timescale 1ns/100ps
module test_cb_store_miss;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         st_valid = 1'b0, st_ready;
  logic [28:0]  st_addr = '0;
  logic [1:0]   st_size = '0;
  logic [63:0]  st_data = '0;
  logic [8:0]   arr_idx;
  logic [14:0]  arr_tag_rd;
  logic         arr_valid_rd, arr_dirty_rd;
  logic [255:0] arr_line_rd;
  logic         arr_we;
  logic [14:0]  arr_tag_wr;
  logic [255:0] arr_line_wr;
  logic         mem_valid, mem_we, mem_ready = 1'b1;
  logic [28:0]  mem_addr;
  logic [31:0]  mem_wdata, mem_rdata;

  logic [14:0]  b_tag  [512];
  logic         b_v    [512];
  logic         b_d    [512];
  logic [255:0] b_line [512];

  int n_chk = 0, n_fail = 0, phase = 0, rmode = 0;
  bit acc_seen = 0, done = 0;
  logic [28:0]  exp_rd[$], exp_wa[$];
  logic [31:0]  exp_wd[$];
  logic [255:0] exp_line;
  logic [31:0]  exp_bm;
  logic [14:0]  exp_tag;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [28:0] a);
    return ({3'b0, a} * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  assign mem_rdata    = pat(mem_addr);
  assign arr_tag_rd   = b_tag[arr_idx];
  assign arr_valid_rd = b_v[arr_idx];
  assign arr_dirty_rd = b_d[arr_idx];
  assign arr_line_rd  = b_line[arr_idx];

  cb_store_miss i_cb_store_miss (.*);

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) mem_ready = (rmode == 0) ? 1'b1 : ($urandom % 3 != 0);

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      case (phase)
        0: begin
          chk(st_ready == 1'b1, "R8 ready when idle", st_ready, 1);
          chk(!mem_valid && !arr_we, "R7 no activity when idle", {mem_valid, arr_we}, 0);
          if (st_valid) begin
            int nb, off;
            logic [8:0] idx;
            logic [31:0] w;
            idx = st_addr[13:5];
            chk(arr_idx == idx, "R1 index", arr_idx, idx);
            nb = 1 << st_size; off = int'(st_addr[4:0]);
            exp_tag = st_addr[28:14]; exp_bm = '0;
            for (int i = 0; i < 8; i++)
              exp_rd.push_back({st_addr[28:5], 3'((int'(st_addr[4:2]) + i) % 8), 2'b00});
            for (int b = 0; b < 32; b++) begin
              if (b >= off && b < off + nb) begin
                exp_line[b*8 +: 8] = st_data[(b-off)*8 +: 8];
                exp_bm[b] = 1'b1;
              end else begin
                w = pat({st_addr[28:5], 3'(b/4), 2'b00});
                exp_line[b*8 +: 8] = w[(b%4)*8 +: 8];
              end
            end
            if (b_v[idx] && b_d[idx])
              for (int k = 0; k < 8; k++) begin
                exp_wa.push_back({b_tag[idx], idx, 3'(k), 2'b00});
                exp_wd.push_back(b_line[idx][k*32 +: 32]);
              end
            acc_seen = 1; phase = 1;
          end
        end
        1: begin
          chk(st_ready == 1'b0, "R9 stalled during refill", st_ready, 0);
          chk(mem_valid && !mem_we && !arr_we, "R4 read beat", {mem_valid, mem_we, arr_we}, 3'b100);
          chk(mem_addr == exp_rd[0], "R4 refill address", mem_addr, exp_rd[0]);
          if (mem_ready) begin
            void'(exp_rd.pop_front());
            if (exp_rd.size() == 0) phase = 2;
          end
        end
        2: begin
          logic [255:0] bits;
          for (int b = 0; b < 32; b++) bits[b*8 +: 8] = {8{exp_bm[b]}};
          chk(arr_we && !mem_valid, "R6 array write", {arr_we, mem_valid}, 2'b10);
          chk(arr_tag_wr == exp_tag, "R6 tag", arr_tag_wr, exp_tag);
          chk((arr_line_wr & bits) == (exp_line & bits), "R3 store bytes", arr_line_wr & bits, exp_line & bits);
          chk((arr_line_wr & ~bits) == (exp_line & ~bits), "R5 refill bytes", arr_line_wr & ~bits, exp_line & ~bits);
          chk(st_ready == 1'b0, "R9 stalled at array write", st_ready, 0);
          b_tag[arr_idx] = arr_tag_wr; b_line[arr_idx] = arr_line_wr;
          b_v[arr_idx] = 1'b1; b_d[arr_idx] = 1'b1;
          phase = (exp_wa.size() != 0) ? 3 : 0;
        end
        default: begin
          chk(st_ready == 1'b0, "R9 stalled during drain", st_ready, 0);
          chk(mem_valid && mem_we && !arr_we, "R7 write beat", {mem_valid, mem_we, arr_we}, 3'b110);
          chk(mem_addr == exp_wa[0], "R2 victim address", mem_addr, exp_wa[0]);
          chk(mem_wdata == exp_wd[0], "R2 victim data", mem_wdata, exp_wd[0]);
          if (mem_ready) begin
            void'(exp_wa.pop_front()); void'(exp_wd.pop_front());
            if (exp_wa.size() == 0) phase = 0;
          end
        end
      endcase
    end
  end

  task automatic setup_line(input logic [28:0] a, input logic [14:0] t, input bit v, input bit d);
    b_tag[a[13:5]] = t; b_v[a[13:5]] = v; b_d[a[13:5]] = d;
    for (int k = 0; k < 8; k++) b_line[a[13:5]][k*32 +: 32] = 32'hC0DE0000 ^ {17'(t), 12'(a[13:5]), 3'(k)};
  endtask

  task automatic issue(input logic [28:0] a, input logic [1:0] sz, input logic [63:0] d, input bit wait_idle);
    @(negedge clk);
    if (wait_idle) while (phase != 0) @(negedge clk);
    acc_seen = 0;
    st_addr = a; st_size = sz; st_data = d; st_valid = 1'b1;
    do @(negedge clk); while (!acc_seen);
    st_valid = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (phase != 0);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin b_tag[i] = '0; b_v[i] = 0; b_d[i] = 0; b_line[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(st_ready && !mem_valid && !arr_we, "R11 reset state", {st_ready, mem_valid, arr_we}, 3'b100);
    // R2 R4 R5: dirty victim, longword store at lw5
    setup_line(29'h0123_4074, 15'h1ABC, 1, 1);
    issue(29'h0123_4074, 2'd2, 64'hDEADBEEF, 1); settle();
    // R3 R4: byte at last byte, wraps from lw7, irregular ready (R10)
    rmode = 1;
    setup_line(29'h0055_A09F, 15'h0777, 1, 1);
    issue(29'h0055_A09F, 2'd0, 64'hA5, 1); settle();
    // R7: clean victim, no drain
    setup_line(29'h0002_0C4A, 15'h0001, 1, 0);
    issue(29'h0002_0C4A, 2'd1, 64'h5AC3, 1); settle();
    // R7: invalid victim, quadword store
    rmode = 0;
    setup_line(29'h1FFF_FFF8, 15'h7FFF, 0, 1);
    issue(29'h1FFF_FFF8, 2'd3, 64'h0102030405060708, 1); settle();
    // R3: quadword at line start with dirty victim
    rmode = 1;
    setup_line(29'h0400_0100, 15'h2222, 1, 1);
    issue(29'h0400_0100, 2'd3, 64'hFEDCBA9876543210, 1); settle();
    // R9: second miss held while the first drains
    setup_line(29'h0800_0220, 15'h3333, 1, 1);
    setup_line(29'h0800_0440, 15'h4444, 1, 1);
    issue(29'h0800_0230, 2'd2, 64'h11112222, 1);
    issue(29'h0800_0446, 2'd1, 64'hBEEF, 0); settle();
    // R3 R4: sweep of sizes and offsets
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 32; o += 8 >> (3 - s) == 0 ? 1 : (1 << s)) begin
        logic [28:0] a;
        a = {10'(s + 5), 9'(o + 16*s), 5'(0), 5'(o)};
        setup_line(a, 15'(o * 37 + s), 1, (o % 3) != 0);
        issue(a, 2'(s), {8{8'(o + 16*s)}} ^ 64'h0F1E2D3C4B5A6978, 1); settle();
      end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule